// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter

This block is a fixed-coefficient halfband low-pass filter that halves the sample rate of a complex baseband stream. It accepts 16-bit signed I and Q samples with a valid strobe. For every second accepted sample it emits one filtered I/Q pair. A typical use is a chain of up to three such stages behind a decimate-by-4 CIC front end, taking a 50 Msps stream down to 25, then 12.5, then 6.25 Msps.

The impulse response has 47 taps and is symmetric about its centre. The centre coefficient is full positive scale, 131071. Away from the centre, only taps at an odd distance from it are non-zero. The two samples that share a coefficient are added first, so each channel needs 12 pair products plus the centre product per output.

The sum is divided by 2^17, rounded half away from zero and clipped to 16 bits. I and Q use the same coefficients but share no arithmetic. Output data change only on the cycle that follows the second accepted sample of each pair.

Top module: `hb_decim2`

## Requirements
- R1: While `rst` is high at a clock edge, the delay line and the decimation phase are cleared. After that edge, `out_valid` is 0 and `out_i` and `out_q` are 0.
- R2: Accepted inputs are counted from reset, starting at index 0. `out_valid` goes high in the cycle after the clock edge that accepts each odd-indexed input (the 2nd, 4th, and so on), and at no other time.
- R3: A cycle with `in_valid` low does not advance the delay line or the phase. In that case `out_valid` is 0 in the next cycle, and `out_i` and `out_q` keep their values.
- R4: Let x[n-k] be the sample accepted k inputs before x[n], with samples before reset taken as 0. The output for input n is round(sum over k of h[k]·x[n-k] / 2^17). The taps are h[23] = 131071 and h[23-d] = h[23+d] = c[(d-1)/2] for odd d from 1 to 23. Here c = 83009, −26536, 14632, −9187, 5990, −3900, 2478, −1505, 855, −440, 194, −62. All taps at even distance d > 0 are 0.
- R5: Rounding is half away from zero. A sum of exactly +2^16 modulo 2^17 rounds up in magnitude, and exactly −2^16 rounds down.
- R6: Results above 32767 are output as 32767, and results below −32768 as −32768.
- R7: The I and Q channels are filtered independently with the same taps, and neither affects the other.
- R8: After a constant input of 1000 on I and −1000 on Q has filled the delay line, the outputs settle at 2000 and −2000. The coefficient sum is 262127.
- R9: `out_valid` is never high in two consecutive cycles.
- R10: A reset asserted in the middle of a stream restarts the phase. The first accepted input after reset produces no output. The second one does, computed with an all-zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_valid | output | 1 | One-cycle strobe for each output pair |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Quadrature output, signed |

## Verification
The bench aims at the rounding tie. The inputs 17473 and 1 place a result of exactly 17473.5 on I and −17473.5 on Q. A truncating design gets one of these wrong, and so does a round-half-up design. Impulses at both decimation phases expose each non-zero tap and the zero taps. A wrong coefficient, a missing pair or a swapped phase shows up as a wrong value at a known output index. Constant full-scale inputs push the result to about twice full scale, so an output that wraps instead of saturating gives a result of the wrong sign. Long random runs with frequent stalls and a mid-stream reset catch a design that advances its delay line on idle cycles, or that keeps its phase across reset and emits its first output one input early.

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int ACC_W = 40,
  parameter int SHIFT = 17,
  parameter int NTAP  = 47
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int CTR   = (NTAP - 1) / 2;
  localparam int NPAIR = (NTAP + 1) / 4;
  localparam int NDL   = NTAP - 1;
  localparam int HALF  = 1 << (SHIFT - 1);
  localparam logic signed [CW-1:0]    C_CTR = CW'((1 << (CW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] YMAX  = ACC_W'((1 << (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] YMIN  = -YMAX - ACC_W'(1);

  function automatic logic signed [CW-1:0] coef(input int j);
    case (j)
      0:  return CW'(83009);
      1:  return CW'(-26536);
      2:  return CW'(14632);
      3:  return CW'(-9187);
      4:  return CW'(5990);
      5:  return CW'(-3900);
      6:  return CW'(2478);
      7:  return CW'(-1505);
      8:  return CW'(855);
      9:  return CW'(-440);
      10: return CW'(194);
      11: return CW'(-62);
      default: return '0;
    endcase
  endfunction

  logic                 phase;
  logic signed [DW-1:0] xin [2];
  logic signed [DW-1:0] dl  [2][NDL];
  logic signed [DW-1:0] y   [2];

  assign xin[0] = in_i;
  assign xin[1] = in_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic signed [DW-1:0]    win [NTAP];
    logic signed [DW:0]      pre [NPAIR];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rsum;
    logic signed [ACC_W-1:0] sh;

    always_comb begin
      win[0] = xin[ch];
      for (int k = 1; k < NTAP; k++) win[k] = dl[ch][k-1];
      acc = ACC_W'(win[CTR]) * ACC_W'(C_CTR);
      for (int j = 0; j < NPAIR; j++) begin
        pre[j] = (DW+1)'(win[CTR-2*j-1]) + (DW+1)'(win[CTR+2*j+1]);
        acc = acc + ACC_W'(pre[j]) * ACC_W'(coef(j));
      end
    end

    assign rsum  = $signed(acc + ACC_W'(HALF) - ACC_W'(acc[ACC_W-1]));
    assign sh    = rsum >>> SHIFT;
    assign y[ch] = (sh > YMAX) ? DW'(YMAX) : (sh < YMIN) ? DW'(YMIN) : sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < NDL; k++) dl[c][k] <= '0;
    end else if (in_valid) begin
      phase <= ~phase;
      for (int c = 0; c < 2; c++) begin
        dl[c][0] <= xin[c];
        for (int k = 1; k < NDL; k++) dl[c][k] <= dl[c][k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid && phase;
      if (in_valid && phase) begin
        out_i <= y[0];
        out_q <= y[1];
      end
    end
  end
endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);
  logic par;

  always_ff @(posedge clk) begin
    if (rst) par <= 1'b0;
    else if (in_valid) par <= ~par;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

  p_phase_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && par && !rst));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind hb_decim2 hb_decim2_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/test_hb_decim2.sv
module test_hb_decim2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int h  [47];
  int hi [47];
  int hq [47];
  int ph = 0;
  int last_i = 0;
  int last_q = 0;

  always #2 clk = ~clk;

  hb_decim2 i_hb_decim2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int x [47]);
    longint acc = 0;
    longint r;
    for (int k = 0; k < 47; k++) acc += longint'(h[k]) * x[k];
    if (acc >= 0) r = (acc + 65536) >>> 17;
    else r = -((-acc + 65536) >>> 17);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 47; k++) begin hi[k] = 0; hq[k] = 0; end
    ph = 0;
    last_i = 0;
    last_q = 0;
  endtask

  task automatic step(input bit v, input int xi, input int xq);
    bit expv;
    int ei, eq;
    in_valid = v;
    in_i = 16'(xi);
    in_q = 16'(xq);
    expv = v && (ph == 1);
    if (v) begin
      for (int k = 46; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
      hi[0] = xi;
      hq[0] = xq;
      ph ^= 1;
    end
    ei = expv ? model(hi) : last_i;
    eq = expv ? model(hq) : last_q;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(v ? "R2 out_valid" : "R3 out_valid on stall", out_valid, expv);
    chk(expv ? "R4 I output" : "R3 I held", out_i, ei);
    chk(expv ? "R7 Q output" : "R3 Q held", out_q, eq);
    last_i = int'(out_i);
    last_q = int'(out_q);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    for (int k = 0; k < 47; k++) h[k] = 0;
    h[23] = 131071;
    h[22] = 83009; h[20] = -26536; h[18] = 14632; h[16] = -9187;
    h[14] = 5990;  h[12] = -3900;  h[10] = 2478;  h[8]  = -1505;
    h[6]  = 855;   h[4]  = -440;   h[2]  = 194;   h[0]  = -62;
    for (int k = 0; k < 23; k++) h[46-k] = h[k];

    do_reset(4);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_i after reset", out_i, 0);
    chk("R1 out_q after reset", out_q, 0);

    // R5: rounding ties
    step(1'b1, 17473, -17473);
    step(1'b1, 1, -1);
    for (int n = 2; n < 24; n++) step(1'b1, 0, 0);
    chk("R5 positive tie", last_i, 17474);
    chk("R5 negative tie", last_q, -17474);

    // R4/R7: impulses at opposite phases
    do_reset(3);
    for (int n = 0; n < 60; n++) begin
      step(1'b1, (n == 1) ? 32767 : 0, (n == 0) ? -32768 : 0);
      if (n == 23) begin
        chk("R4 impulse tap 22", last_i, 20752);
        chk("R7 impulse centre on Q", last_q, -32768);
      end
    end

    // R3: random stream with stalls
    for (int n = 0; n < 1500; n++)
      step(($urandom_range(0, 2) != 0), rnd16(), rnd16());

    // R8: constant input
    do_reset(2);
    for (int n = 0; n < 60; n++) step(1'b1, 1000, -1000);
    chk("R8 DC gain I", last_i, 2000);
    chk("R8 DC gain Q", last_q, -2000);

    // R6: saturation
    do_reset(2);
    for (int n = 0; n < 60; n++) step(1'b1, 32767, -32768);
    chk("R6 saturate high", last_i, 32767);
    chk("R6 saturate low", last_q, -32768);
    for (int n = 0; n < 400; n++)
      step(1'b1, ($urandom_range(0, 1) != 0) ? 32767 : -32768,
           ($urandom_range(0, 1) != 0) ? 32767 : -32768);

    // R10: reset mid-stream with phase at one
    for (int n = 0; n < 3; n++) step(1'b1, rnd16(), rnd16());
    do_reset(1);
    chk("R10 out_valid after mid reset", out_valid, 0);
    chk("R10 out_i after mid reset", out_i, 0);
    step(1'b1, 30000, -30000);
    chk("R10 no output on first input", out_valid, 0);
    step(1'b1, 5, 5);
    chk("R10 output on second input", out_valid, 1);
    for (int n = 0; n < 400; n++)
      step(($urandom_range(0, 3) != 0), rnd16(), rnd16());

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule